// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls a port of 32 general-purpose pins through a zero-wait-state register bus. Writes happen in the same cycle as the request. Each write carries byte-lane strobes, so byte, halfword and word writes are all accepted. Read data is combinational on the address. Bit n of every register belongs to pin n only.

Software sets pin levels through an output data register. It can also use three write-only alias registers that set, clear or invert any group of output bits in a single write. A direction register turns a pin into an output, but only for pins muxed to GPIO. An input-disable register, a per-pin digital-function flag and a port-control enable decide what the input data register shows.

A stop input freezes the block. A mask parameter marks pins that are not bonded out; those pins never drive and always read 0.

Top module: `gpio_port`

## Requirements
- R1: A write changes only the bytes whose strobe in `be_i` is 1 (bit k covers data bits 8k+7..8k). This holds for every register and alias.
- R2: A write to offset 0x00 loads the enabled bytes of the output data register. Offset 0x00 reads back that register.
- R3: Writing to offset 0x04 forces to 1 every output data bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Writing to offset 0x08 forces to 0 every output data bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Writing to offset 0x0C inverts every output data bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: Offsets 0x04, 0x08 and 0x0C read 0, as does any offset that is not decoded. Offset 0x14 is the direction register and offset 0x18 the input-disable register.
- R7: `pin_oe_o[n]` is direction bit n AND `gpio_sel_i[n]`. `pin_o` follows the output data register.
- R8: Each pin passes through two flops before it reaches the input data register at offset 0x10. A level applied before clock edge k can be read after edge k+1.
- R9: An input data bit reads 0 when its input-disable bit is 1 or when `digital_i[n]` is 0.
- R10: While `pctl_en_i` is 0 the input data stops updating and holds its last value. Writes to the output data, alias and direction registers still take effect.
- R11: While `stop_i` is 1, bus writes are ignored, the input data holds, and `pin_o` and `pin_oe_o` keep their values.
- R12: Pins set in `UNBONDED_MASK` read 0 in every register and drive `pin_o` and `pin_oe_o` low.
- R13: After reset every register is 0, so all outputs and all reads are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Stop mode: freezes the block |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when 1 |
| addr_i | input | 5 | Byte address of the register |
| be_i | input | 4 | Byte-lane write strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on `addr_i` |
| pin_i | input | 32 | Pad input levels |
| digital_i | input | 32 | Pin muxed to a digital function |
| gpio_sel_i | input | 32 | Pin muxed to GPIO |
| pctl_en_i | input | 1 | Port-control clock gate on |
| pin_o | output | 32 | Output level per pin |
| pin_oe_o | output | 32 | Output enable per pin |

## Verification
The bench builds the block with `UNBONDED_MASK` = 0xF000_0000. This lets every read and output check, including writes through the aliases, confirm that the top nibble stays at 0 while the stored bits underneath change. The default of 0 leaves every pin bonded. With four unbonded pins, a full-width set or direction write also exercises how the mask interacts with the strobe lanes and with output enable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_SET  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TOG  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IDIS = 5'h18;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     dout_o,
  output logic [DW-1:0]     dir_o,
  output logic [DW-1:0]     idis_o
);
  logic [DW-1:0] lane_m, wm, dout_d, dir_d, idis_d;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_m[8*b +: 8] = {8{be_i[b]}};
  end
  assign wm = wdata_i & lane_m;

  always_comb begin
    dout_d = dout_o;
    dir_d  = dir_o;
    idis_d = idis_o;
    if (wr_i) begin
      unique case (addr_i)
        OFS_DOUT: dout_d = (dout_o & ~lane_m) | wm;
        OFS_SET:  dout_d = dout_o | wm;
        OFS_CLR:  dout_d = dout_o & ~wm;
        OFS_TOG:  dout_d = dout_o ^ wm;
        OFS_DIR:  dir_d  = (dir_o & ~lane_m) | wm;
        OFS_IDIS: idis_d = (idis_o & ~lane_m) | wm;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '0;
      dir_o  <= '0;
      idis_o <= '0;
    end else begin
      dout_o <= dout_d;
      dir_o  <= dir_d;
      idis_o <= idis_d;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else if (en_i) begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int          DW   = 32,
  parameter logic [DW-1:0] MASK = '0
) (
  input  logic [DW-1:0] dout_i,
  input  logic [DW-1:0] dir_i,
  input  logic [DW-1:0] sel_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe_o
);
  assign pin_o    = dout_i & ~MASK;
  assign pin_oe_o = dir_i & sel_i & ~MASK;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int            DW            = 32,
  parameter logic [DW-1:0] UNBONDED_MASK = '0,
  localparam int           NB            = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pin_i,
  input  logic [DW-1:0]     digital_i,
  input  logic [DW-1:0]     gpio_sel_i,
  input  logic              pctl_en_i,
  output logic [DW-1:0]     pin_o,
  output logic [DW-1:0]     pin_oe_o
);
  logic [DW-1:0] dout_q, dir_q, idis_q, din_raw, din_vis;
  logic          wr;

  assign wr = req_i & we_i & ~stop_i;

  gpio_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .be_i, .wdata_i,
    .dout_o(dout_q), .dir_o(dir_q), .idis_o(idis_q)
  );

  gpio_sync #(.DW(DW)) u_sync (
    .clk_i, .rst_ni, .en_i(pctl_en_i & ~stop_i), .d_i(pin_i), .q_o(din_raw)
  );

  gpio_drive #(.DW(DW), .MASK(UNBONDED_MASK)) u_drive (
    .dout_i(dout_q), .dir_i(dir_q), .sel_i(gpio_sel_i),
    .pin_o, .pin_oe_o
  );

  assign din_vis = din_raw & ~idis_q & digital_i;

  always_comb begin
    unique case (addr_i)
      OFS_DOUT: rdata_o = dout_q & ~UNBONDED_MASK;
      OFS_DIN:  rdata_o = din_vis & ~UNBONDED_MASK;
      OFS_DIR:  rdata_o = dir_q & ~UNBONDED_MASK;
      OFS_IDIS: rdata_o = idis_q & ~UNBONDED_MASK;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int            DW            = 32,
  parameter logic [DW-1:0] UNBONDED_MASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW/8-1:0]   be_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [DW-1:0]     gpio_sel_i,
  input logic              pctl_en_i,
  input logic [DW-1:0]     pin_o,
  input logic [DW-1:0]     pin_oe_o,
  input logic [DW-1:0]     din_raw
);
  // R3
  set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !stop_i && addr_i == OFS_SET && &be_i) |=>
      ((pin_o & $past(wdata_i) & ~UNBONDED_MASK) == ($past(wdata_i) & ~UNBONDED_MASK)));
  // R4
  clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !stop_i && addr_i == OFS_CLR && &be_i) |=>
      ((pin_o & $past(wdata_i)) == '0));
  // R6
  alias_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_SET || addr_i == OFS_CLR || addr_i == OFS_TOG) |-> rdata_o == '0);
  // R7
  oe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~gpio_sel_i) == '0);
  // R10
  din_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pctl_en_i |=> $stable(din_raw));
  // R11
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(din_raw)));
  // R12
  unbonded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o | pin_o | pin_oe_o) & UNBONDED_MASK) == '0);
endmodule

bind gpio_port gpio_port_chk #(.DW(DW), .UNBONDED_MASK(UNBONDED_MASK)) u_chk (
  .clk_i, .rst_ni, .stop_i, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
  .gpio_sel_i, .pctl_en_i, .pin_o, .pin_oe_o, .din_raw
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] UNB = 32'hF000_0000;

  typedef struct packed {
    logic [4:0]  a;
    logic [3:0]  be;
    logic [31:0] w;
    logic [31:0] exp;
  } vec_t;

  // Output data register read back after each write (R1..R5, R12)
  localparam vec_t VECS [8] = '{
    '{5'h00, 4'hF, 32'h0000_00FF, 32'h0000_00FF},
    '{5'h04, 4'hF, 32'h0000_FF00, 32'h0000_FFFF},
    '{5'h08, 4'h1, 32'hFFFF_FF0F, 32'h0000_FFF0},
    '{5'h0C, 4'h2, 32'h0000_FF00, 32'h0000_00F0},
    '{5'h0C, 4'hC, 32'h00FF_0000, 32'h00FF_00F0},
    '{5'h00, 4'h4, 32'h0055_0000, 32'h0055_00F0},
    '{5'h04, 4'h8, 32'hFF00_0000, 32'h0F55_00F0},
    '{5'h08, 4'hF, 32'h0000_0000, 32'h0F55_00F0}
  };

  logic clk = 0, rst_n = 0, stop = 0, req = 0, we = 0, pctl = 1;
  logic [4:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, dig = '1, sel = '0, pin_out, pin_oe;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.UNBONDED_MASK(UNB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin_in), .digital_i(dig), .gpio_sel_i(sel), .pctl_en_i(pctl),
    .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input string r, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(r, rdata, exp);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    edges(3);
    // R13 reset state
    rd("R13", 5'h00, 32'h0);
    rd("R13", 5'h14, 32'h0);
    rd("R13", 5'h18, 32'h0);
    check("R13", pin_out | pin_oe, 32'h0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].a, VECS[i].be, VECS[i].w);
      rd("R1/R2/R3/R4/R5 vector", 5'h00, VECS[i].exp);
    end
    check("R12 pin_o", pin_out, 32'h0F55_00F0);

    // R6 alias and undecoded offsets read 0
    rd("R6 set", 5'h04, 32'h0);
    rd("R6 tog", 5'h0C, 32'h0);
    rd("R6 undecoded", 5'h1C, 32'h0);

    // R7 direction gated by GPIO mux
    wr(5'h14, 4'hF, 32'h0000_00FF);
    rd("R6 dir", 5'h14, 32'h0000_00FF);
    @(negedge clk) sel = 32'h0000_000F;
    #1 check("R7 oe", pin_oe, 32'h0000_000F);
    wr(5'h14, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk) sel = '1;
    #1 check("R12 oe", pin_oe, 32'h0FFF_FFFF);

    // R8 two-flop latency
    @(negedge clk);
    addr = 5'h10; pin_in = 32'hA5A5_A5A5;
    @(posedge clk); #1 check("R8 one edge", rdata, 32'h0);
    @(posedge clk); #1 check("R8 two edges", rdata, 32'h05A5_A5A5);

    // R9 input disable and digital flag
    wr(5'h18, 4'hF, 32'h0000_00FF);
    rd("R9 idis", 5'h10, 32'h05A5_A500);
    @(negedge clk) dig = 32'hFFFF_0000;
    rd("R9 digital", 5'h10, 32'h05A5_0000);
    @(negedge clk) dig = '1;

    // R10 freeze with port control off, writes still land
    @(negedge clk) begin pctl = 0; pin_in = 32'h5A5A_5A5A; end
    edges(3);
    rd("R10 frozen", 5'h10, 32'h05A5_A500);
    wr(5'h00, 4'hF, 32'h0000_0001);
    rd("R10 write while off", 5'h00, 32'h0000_0001);

    // R11 stop blocks writes and input capture
    @(negedge clk) begin pctl = 1; stop = 1; end
    edges(3);
    rd("R11 input hold", 5'h10, 32'h05A5_A500);
    wr(5'h00, 4'hF, 32'h0000_FFFF);
    rd("R11 write ignored", 5'h00, 32'h0000_0001);
    check("R11 pin_o hold", pin_out, 32'h0000_0001);
    @(negedge clk) begin stop = 0; addr = 5'h10; end
    @(posedge clk); @(posedge clk); #1 check("R8/R11 resume", rdata, 32'h0A5A_5A00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule